// File: doc/BRIEF.md
# Converter Readout Serial Target

This block is the two-wire serial target for a delta-sigma converter. It oversamples the open-drain SCL and SDA lines in the system clock domain and pulls SDA low through an output enable. A transaction opens with an address byte made of a fixed four-bit device code, three board-selected address bits and a direction bit. A write carries a configuration byte that is handed to the mode/ready controller through a one-cycle strobe. A read returns the conversion result, MSB first, and then the controller's configuration/status byte.

For as long as the master keeps acknowledging and clocking after the result, each further byte repeats that status byte. The status byte is sampled fresh for every byte, so the master can watch the ready flag flip within a single read and then NAK and STOP. The result word is captured when a read address is acknowledged. A pulse tells the controller that the last result byte has been acknowledged, so it can mark the data as consumed.

Top module: `i2c_adc_target`

## Requirements
- R1: After reset, sda_oe, cfg_wr and rd_done are all 0.
- R2: An address byte equal to {DEV_CODE, addr_sel, rw}, sent MSB first, is acknowledged: the target holds SDA low for the whole ninth clock.
- R3: When either the device code or the address bits differ, the target never drives SDA and raises no strobe until the next START. This covers the acknowledge slot and any bytes that follow.
- R4: In a write (rw=0), each byte after the address is acknowledged. It appears on cfg_data together with a cfg_wr pulse exactly one clock long.
- R5: In a read (rw=1) with res_wide=1, the first three bytes are result[23:16], result[15:8] and result[7:0], each MSB first. The result is taken as it stood when the read address was acknowledged.
- R6: In a read with res_wide=0, the first two bytes are result[15:8] and result[7:0]. The controller supplies the narrower results already sign-extended into these 16 bits.
- R7: Every byte after the result bytes is the status input. It is sampled at the SCL falling edge that ends the previous byte's acknowledge slot.
- R8: rd_done pulses for one clock when the master acknowledges the last result byte. It pulses only once per read, and not at all if the master NAKs an earlier byte.
- R9: After a NAK from the master the target releases SDA. It keeps SDA released through any further clocks until the next START.
- R10: sda_oe changes only while SCL is low. START and STOP conditions are the exceptions.
- R11: A START, including a repeated START in the middle of any byte, aborts the transfer in progress and begins a new address byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| addr_sel | input | 3 | Static board address bits |
| res_wide | input | 1 | 1: three-byte result, 0: two-byte result |
| result | input | 24 | Latest conversion result |
| status | input | 8 | Live configuration/status byte |
| cfg_wr | output | 1 | One-cycle configuration write strobe |
| cfg_data | output | 8 | Written configuration byte |
| rd_done | output | 1 | One-cycle strobe, last result byte acknowledged |

## Verification
The bench uses the default device code 1101 and the two-flop synchroniser, and ties addr_sel to 101. With those values a single wrong bit in either the code field or the address field is enough to test the silent-mismatch path. The bench holds SCL low for twelve system clocks, which leaves room for the three-cycle input-to-drive latency, so the bench's every-clock check that sda_oe holds still while SCL is high becomes meaningful. It reads in both result widths and changes status between bytes, which exposes exactly when the repeated status byte is sampled.

// File: rtl/i2c_adc_target.sv
module i2c_adc_target #(
  parameter logic [3:0] DEV_CODE    = 4'b1101,
  parameter int         SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe,
  input  logic [2:0]  addr_sel,
  input  logic        res_wide,
  input  logic [23:0] result,
  input  logic [7:0]  status,
  output logic        cfg_wr,
  output logic [7:0]  cfg_data,
  output logic        rd_done
);

  localparam logic [2:0] S_IDLE = 3'd0, S_ADDR = 3'd1, S_AACK = 3'd2, S_WR = 3'd3,
                         S_WACK = 3'd4, S_TX = 3'd5, S_MACK = 3'd6, S_MNXT = 3'd7;

  logic [SYNC_STAGES:0] scl_q, sda_q;
  logic s_scl, p_scl, s_sda, p_sda;
  logic start_c, stop_c, rise, fall;

  assign s_scl = scl_q[SYNC_STAGES-1];
  assign p_scl = scl_q[SYNC_STAGES];
  assign s_sda = sda_q[SYNC_STAGES-1];
  assign p_sda = sda_q[SYNC_STAGES];
  assign start_c = s_scl & p_scl & p_sda & ~s_sda;
  assign stop_c  = s_scl & p_scl & ~p_sda & s_sda;
  assign rise    = s_scl & ~p_scl;
  assign fall    = ~s_scl & p_scl;

  logic [2:0]  st;
  logic [3:0]  cnt;
  logic [7:0]  sh, tx, nxt;
  logic        rw, wide;
  logic [2:0]  idx, idx_inc, done_idx;
  logic [23:0] snap;

  assign done_idx = wide ? 3'd3 : 3'd2;
  assign idx_inc  = (idx == 3'd4) ? idx : idx + 3'd1;

  always_comb begin
    case ({wide, idx})
      4'b1_000:           nxt = snap[23:16];
      4'b1_001, 4'b0_000: nxt = snap[15:8];
      4'b1_010, 4'b0_001: nxt = snap[7:0];
      default:            nxt = status;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q    <= '1;
      sda_q    <= '1;
      st       <= S_IDLE;
      cnt      <= '0;
      sh       <= '0;
      tx       <= '0;
      rw       <= 1'b0;
      wide     <= 1'b0;
      idx      <= '0;
      snap     <= '0;
      sda_oe   <= 1'b0;
      cfg_wr   <= 1'b0;
      cfg_data <= '0;
      rd_done  <= 1'b0;
    end else begin
      scl_q   <= {scl_q[SYNC_STAGES-1:0], scl_i};
      sda_q   <= {sda_q[SYNC_STAGES-1:0], sda_i};
      cfg_wr  <= 1'b0;
      rd_done <= 1'b0;
      if (start_c) begin
        st     <= S_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_c) begin
        st     <= S_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          S_ADDR, S_WR: begin
            if (rise) begin
              sh  <= {sh[6:0], s_sda};
              cnt <= cnt + 4'd1;
            end else if (fall && cnt == 4'd8) begin
              if (st == S_WR) begin
                cfg_wr   <= 1'b1;
                cfg_data <= sh;
                sda_oe   <= 1'b1;
                st       <= S_WACK;
              end else if (sh[7:1] == {DEV_CODE, addr_sel}) begin
                sda_oe <= 1'b1;
                rw     <= sh[0];
                idx    <= '0;
                snap   <= result;
                wide   <= res_wide;
                st     <= S_AACK;
              end else begin
                st <= S_IDLE;
              end
            end
          end
          S_AACK: if (fall) begin
            cnt <= '0;
            if (rw) begin
              tx     <= nxt;
              sda_oe <= ~nxt[7];
              idx    <= idx_inc;
              st     <= S_TX;
            end else begin
              sda_oe <= 1'b0;
              st     <= S_WR;
            end
          end
          S_WACK: if (fall) begin
            sda_oe <= 1'b0;
            cnt    <= '0;
            st     <= S_WR;
          end
          S_TX: begin
            if (rise) cnt <= cnt + 4'd1;
            else if (fall) begin
              if (cnt == 4'd8) begin
                sda_oe <= 1'b0;
                st     <= S_MACK;
              end else begin
                tx     <= {tx[6:0], 1'b0};
                sda_oe <= ~tx[6];
              end
            end
          end
          S_MACK: if (rise) begin
            if (s_sda) st <= S_IDLE;
            else begin
              st <= S_MNXT;
              if (idx == done_idx) rd_done <= 1'b1;
            end
          end
          S_MNXT: if (fall) begin
            tx     <= nxt;
            sda_oe <= ~nxt[7];
            idx    <= idx_inc;
            cnt    <= '0;
            st     <= S_TX;
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/i2c_adc_target_chk.sv
module i2c_adc_target_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sda_oe,
  input logic       cfg_wr,
  input logic       rd_done,
  input logic [2:0] st,
  input logic       s_scl,
  input logic       p_scl,
  input logic       start_c,
  input logic       stop_c
);

  p_cfg_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> !cfg_wr);

  p_strobe_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_wr && rd_done));

  p_rd_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |=> !rd_done);

  p_rd_released_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |-> !sda_oe);

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd0) |-> !sda_oe);

  p_oe_hold_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (s_scl && p_scl && !start_c && !stop_c) |=> $stable(sda_oe));

  p_start_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
    start_c |=> (st == 3'd1 && !sda_oe));

endmodule

bind i2c_adc_target i2c_adc_target_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .cfg_wr(cfg_wr), .rd_done(rd_done),
  .st(st), .s_scl(s_scl), .p_scl(p_scl), .start_c(start_c), .stop_c(stop_c)
);

// File: tb/sim_i2c_adc_target.sv
`timescale 1ns/1ps
module sim_i2c_adc_target;
  localparam int H = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_line;
  logic sda_oe, cfg_wr, rd_done;
  logic [7:0] cfg_data;
  logic [2:0] addr_sel = 3'b101;
  logic res_wide = 1'b1;
  logic [23:0] result = '0;
  logic [7:0] status = '0;

  int total = 0, fails = 0;
  int ncfg = 0, nrd = 0, viol = 0;
  logic [7:0] last_cfg = '0;
  logic prev_scl = 1'b1, prev_oe = 1'b0;

  always #2.5 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  i2c_adc_target u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .addr_sel(addr_sel), .res_wide(res_wide), .result(result), .status(status),
    .cfg_wr(cfg_wr), .cfg_data(cfg_data), .rd_done(rd_done)
  );

  always @(negedge clk) begin
    if (cfg_wr) begin ncfg++; last_cfg = cfg_data; end
    if (rd_done) nrd++;
    if (rst_n && scl_m && prev_scl && sda_oe != prev_oe) viol++;
    prev_scl = scl_m;
    prev_oe  = sda_oe;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bit_io(input logic b, output logic seen);
    sda_m = b; tick(H);
    scl_m = 1'b1; tick(H/2);
    seen = sda_line; tick(H/2);
    scl_m = 1'b0; tick(4);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; tick(H);
    scl_m = 1'b1; tick(H);
    sda_m = 1'b0; tick(H);
    scl_m = 1'b0; tick(4);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; tick(H);
    scl_m = 1'b1; tick(H);
    sda_m = 1'b1; tick(H);
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_io(b[i], s);
    bit_io(1'b1, s);
    ack = ~s;
  endtask

  task automatic rd_byte(input logic mack, output logic [7:0] v);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bit_io(1'b1, s);
      v[i] = s;
    end
    bit_io(~mack, s);
  endtask

  logic a;
  logic [7:0] v;

  initial begin
    repeat (200000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    tick(3);
    chk("R1 oe", sda_oe, 0);
    chk("R1 cfg_wr", cfg_wr, 0);
    chk("R1 rd_done", rd_done, 0);
    rst_n = 1'b1;
    tick(6);

    // write with matching address
    bus_start;
    wr_byte(8'hDA, a); chk("R2 write addr ack", a, 1);
    wr_byte(8'h9C, a); chk("R4 cfg ack", a, 1);
    bus_stop;
    chk("R4 cfg strobe count", ncfg, 1);
    chk("R4 cfg data", last_cfg, 8'h9C);

    // address bits differ
    bus_start;
    wr_byte(8'hD8, a); chk("R3 addr bits mismatch", a, 0);
    wr_byte(8'h55, a); chk("R3 data ignored ack", a, 0);
    bus_stop;
    chk("R3 no cfg strobe", ncfg, 1);

    // device code differs
    bus_start;
    wr_byte(8'hCB, a); chk("R3 code mismatch", a, 0);
    rd_byte(1'b1, v); chk("R3 silent read", v, 8'hFF);
    bus_stop;
    chk("R3 no rd strobe", nrd, 0);

    // three-byte read with status polling
    res_wide = 1'b1; result = 24'h3A5C71; status = 8'h92;
    bus_start;
    wr_byte(8'hDB, a); chk("R2 read addr ack", a, 1);
    result = 24'h000000;
    rd_byte(1'b1, v); chk("R5 byte0", v, 8'h3A);
    rd_byte(1'b1, v); chk("R5 byte1", v, 8'h5C);
    chk("R8 no strobe before last", nrd, 0);
    rd_byte(1'b1, v); chk("R5 byte2", v, 8'h71);
    chk("R8 strobe after last", nrd, 1);
    status = 8'h12;
    rd_byte(1'b1, v); chk("R7 status first", v, 8'h92);
    rd_byte(1'b0, v); chk("R7 status live", v, 8'h12);
    chk("R9 released after nak", sda_oe, 0);
    bus_stop;
    chk("R8 single strobe", nrd, 1);

    // two-byte read
    res_wide = 1'b0; result = 24'hFFF3A7; status = 8'h6B;
    bus_start;
    wr_byte(8'hDB, a); chk("R2 narrow addr ack", a, 1);
    rd_byte(1'b1, v); chk("R6 byte0", v, 8'hF3);
    chk("R8 narrow none yet", nrd, 1);
    rd_byte(1'b1, v); chk("R6 byte1", v, 8'hA7);
    chk("R8 narrow strobe", nrd, 2);
    rd_byte(1'b1, v); chk("R7 narrow status", v, 8'h6B);
    rd_byte(1'b0, v); chk("R7 narrow repeat", v, 8'h6B);
    bus_stop;
    chk("R8 narrow single", nrd, 2);

    // early NAK, extra clocks, repeated start into write
    res_wide = 1'b1; result = 24'h00FF00;
    bus_start;
    wr_byte(8'hDB, a);
    rd_byte(1'b0, v); chk("R5 early byte0", v, 8'h00);
    rd_byte(1'b1, v); chk("R9 silent after nak", v, 8'hFF);
    chk("R8 no strobe on early nak", nrd, 2);
    bus_start;
    wr_byte(8'hDA, a); chk("R11 restart addr ack", a, 1);
    wr_byte(8'h41, a); chk("R11 restart cfg ack", a, 1);
    bus_stop;
    chk("R11 cfg count", ncfg, 2);
    chk("R11 cfg data", last_cfg, 8'h41);

    // repeated start between write address and read
    result = 24'hC3_0000;
    bus_start;
    wr_byte(8'hDA, a);
    bus_start;
    wr_byte(8'hDB, a); chk("R11 reread ack", a, 1);
    rd_byte(1'b0, v); chk("R11 reread byte0", v, 8'hC3);
    bus_stop;
    chk("R11 no stray cfg", ncfg, 2);

    chk("R10 oe stable while SCL high", viol, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule